// File: doc/BRIEF.md
# Interrupt Redirection Controller

The block takes a set of interrupt input pins and turns them into interrupt messages on a valid/ready message port. Each pin has a 64-bit redirection entry. The entry gives the vector, the delivery type, the destination addressing mode, the destination, the pin polarity, the trigger mode and a mask bit. Software reaches every internal register indirectly. It first writes an 8-bit index at byte offset 0x00 of a small bus window. It then reads or writes a 32-bit data window at byte offset 0x10.

Each input is synchronised with two flops and corrected for its programmed polarity. In edge mode a pin produces one message per inactive-to-active transition. In level mode a pin produces a message while it is active, and then blocks behind a remote-IRR flag. That flag is cleared only by an end-of-interrupt notification that carries the entry's vector. Pending pins are served lowest pin number first. The message fields stay stable until the consumer accepts them.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset the index register and the ID register read 0. The low half of every entry reads 0x00010000 (only the mask bit set), and the high half of every entry reads 0.
- R2: A write at byte offset 0x00 loads the index from bits 7:0, and a read there returns the index. Offset 0x10 is the data window for the register the index selects. Any other offset reads 0, and writes to it are ignored.
- R3: Index 0x00 is the ID register: bits 31:24 are writable and all other bits read 0. Index 0x01 is read-only and returns version 0x20 in bits 7:0 and NUM_PINS-1 in bits 23:16. Index 0x02 is read-only and returns ID bits 3:0 in bits 27:24.
- R4: Entry n has its low half at index 0x10+2n and its high half at index 0x11+2n. The low half holds the following fields:
  - vector in bits 7:0
  - delivery type in bits 10:8
  - destination mode in bit 11
  - delivery status in bit 12 (read-only)
  - polarity in bit 13
  - remote IRR in bit 14 (read-only)
  - trigger mode in bit 15
  - mask in bit 16

  The high half holds the destination in bits 31:24. All other bits read 0. Each half takes effect on its own write. An index past the last entry reads 0 and ignores writes.
- R5: In edge mode (bit 15 = 0) an unmasked pin raises exactly one message per inactive-to-active transition. Polarity bit 13 = 0 means active high and 1 means active low. A pin held active raises no further messages.
- R6: A pin whose mask bit is set raises no message and sets no delivery status. Unmasking an edge-mode pin that is already active raises nothing.
- R7: In level mode (bit 15 = 1) an active, unmasked pin with remote IRR clear raises a message. Acceptance of that message sets remote IRR. No further message follows until an end-of-interrupt with the entry's vector clears remote IRR. After that, a pin that is still active raises a new message.
- R8: An end-of-interrupt whose vector differs from an entry's vector leaves that entry's remote IRR set.
- R9: Delivery status (bit 12) reads 1 from event detection until the message handshake completes, then reads 0.
- R10: When several pins are pending at once, the lowest-numbered pin is delivered first.
- R11: A message carries the entry's vector, delivery type, destination mode, destination and trigger mode. `msg_valid` stays high and every field stays stable until `msg_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NUM_PINS | Interrupt input pins (asynchronous) |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| msg_valid | output | 1 | Interrupt message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dlv_mode | output | 3 | Message delivery type |
| msg_dest_mode | output | 1 | 0 physical, 1 logical |
| msg_dest | output | 8 | Destination |
| msg_level | output | 1 | 1 when the source entry is level triggered |
| eoi_valid | input | 1 | End-of-interrupt notification strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
The bench targets the following corner cases:

- **Read-only and reserved bits.** It writes all ones to an entry. A design that let those writes land on delivery status or remote IRR would read back stray bits.
- **Index past the table.** It accesses an index beyond the last entry. A design that aliased it onto a real entry would corrupt that entry.
- **Re-arming an edge pin.** It holds an edge pin active after acceptance and checks for silence. A design that re-armed would flood messages.
- **Polarity change with the pin already active.** It changes polarity while masked and then unmasks. A design that updated its edge history only while unmasked would fire a spurious message.
- **End-of-interrupt matching.** It sends an end-of-interrupt with the wrong vector and then the right one. A design matching the wrong field would free the pin early or never.
- **Arbitration order.** It raises two pins in the same cycle. A design with reversed priority would deliver the higher pin first.

// File: rtl/irc_pkg.sv
package irc_pkg;

  // Bus window byte offsets
  localparam logic [4:0] OFS_INDEX  = 5'h00;
  localparam logic [4:0] OFS_WINDOW = 5'h10;

  // Internal register indices
  localparam logic [7:0] IDX_ID    = 8'h00;
  localparam logic [7:0] IDX_VER   = 8'h01;
  localparam logic [7:0] IDX_ARB   = 8'h02;
  localparam logic [7:0] IDX_TABLE = 8'h10;

  // Bit positions inside the low half of an entry
  localparam int B_DMODE = 11;
  localparam int B_PEND  = 12;
  localparam int B_POL   = 13;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
  } irc_entry_t;

  localparam irc_entry_t ENTRY_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                       pol: 1'b0, dmode: 1'b0, dlv: 3'b000,
                                       vec: 8'h00};

endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_en,
  input  logic                            bus_wr,
  input  logic [4:0]                      bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic [NUM_PINS-1:0]             pending,
  input  logic [NUM_PINS-1:0]             rirr_set,
  input  logic                            eoi_valid,
  input  logic [7:0]                      eoi_vector,
  output irc_entry_t [NUM_PINS-1:0]       entries,
  output logic [NUM_PINS-1:0]             rirr
);

  localparam logic [8:0] TABLE_SPAN = 9'(2 * NUM_PINS);

  logic [7:0]                  index_q, index_d;
  logic [7:0]                  id_q, id_d;
  irc_entry_t [NUM_PINS-1:0]   ent_q, ent_d;
  logic [NUM_PINS-1:0]         rirr_q, rirr_d;

  logic       idx_sel, win_sel, tbl_hit, hi_half;
  logic [7:0] ent_off, ent_num;
  irc_entry_t rd_ent;
  logic       rd_pend, rd_rirr;
  logic       unused_wbits;

  assign idx_sel = bus_en && (bus_addr == OFS_INDEX);
  assign win_sel = bus_en && (bus_addr == OFS_WINDOW);
  assign ent_off = index_q - IDX_TABLE;
  assign ent_num = {1'b0, ent_off[7:1]};
  assign hi_half = index_q[0];
  assign tbl_hit = (index_q >= IDX_TABLE) && ({1'b0, ent_off} < TABLE_SPAN);

  assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[B_RIRR], bus_wdata[B_PEND]};

  // Next state: index, ID, entries
  always_comb begin
    index_d = index_q;
    id_d    = id_q;
    ent_d   = ent_q;
    if (idx_sel && bus_wr) begin
      index_d = bus_wdata[7:0];
    end
    if (win_sel && bus_wr) begin
      if (index_q == IDX_ID) begin
        id_d = bus_wdata[31:24];
      end
      for (int i = 0; i < NUM_PINS; i++) begin
        if (tbl_hit && (ent_num == 8'(i))) begin
          if (hi_half) begin
            ent_d[i].dest = bus_wdata[31:24];
          end else begin
            ent_d[i].vec   = bus_wdata[7:0];
            ent_d[i].dlv   = bus_wdata[10:8];
            ent_d[i].dmode = bus_wdata[B_DMODE];
            ent_d[i].pol   = bus_wdata[B_POL];
            ent_d[i].trig  = bus_wdata[B_TRIG];
            ent_d[i].mask  = bus_wdata[B_MASK];
          end
        end
      end
    end
  end

  // Next state: remote IRR; a new acceptance wins over a same-cycle EOI
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      rirr_d[i] = rirr_q[i];
      if (eoi_valid && (eoi_vector == ent_q[i].vec)) begin
        rirr_d[i] = 1'b0;
      end
      if (rirr_set[i]) begin
        rirr_d[i] = 1'b1;
      end
    end
  end

  // Read path
  always_comb begin
    rd_ent  = ENTRY_RST;
    rd_pend = 1'b0;
    rd_rirr = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (ent_num == 8'(i)) begin
        rd_ent  = ent_q[i];
        rd_pend = pending[i];
        rd_rirr = rirr_q[i];
      end
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_en && (bus_addr == OFS_INDEX)) begin
      bus_rdata = {24'h0, index_q};
    end else if (win_sel) begin
      if (index_q == IDX_ID) begin
        bus_rdata = {id_q, 24'h0};
      end else if (index_q == IDX_VER) begin
        bus_rdata = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
      end else if (index_q == IDX_ARB) begin
        bus_rdata = {4'h0, id_q[3:0], 24'h0};
      end else if (tbl_hit) begin
        if (hi_half) begin
          bus_rdata = {rd_ent.dest, 24'h0};
        end else begin
          bus_rdata = {15'h0, rd_ent.mask, rd_ent.trig, rd_rirr, rd_ent.pol,
                       rd_pend, rd_ent.dmode, rd_ent.dlv, rd_ent.vec};
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      id_q    <= 8'h00;
      rirr_q  <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        ent_q[i] <= ENTRY_RST;
      end
    end else begin
      index_q <= index_d;
      id_q    <= id_d;
      rirr_q  <= rirr_d;
      ent_q   <= ent_d;
    end
  end

  assign entries = ent_q;
  assign rirr    = rirr_q;

endmodule

// File: rtl/irc_pin_sense.sv
module irc_pin_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  input  logic trig,
  input  logic mask,
  input  logic rirr,
  input  logic ack,
  output logic pend
);

  logic sync1_q, sync2_q;
  logic act_q;
  logic pend_q, pend_d;
  logic act, edge_ev, lvl_ev;

  // Polarity-corrected synchronised level
  assign act     = sync2_q ^ pol;
  assign edge_ev = !trig && act && !act_q && !mask;
  assign lvl_ev  = trig && act && !mask && !rirr;

  always_comb begin
    if (ack) begin
      pend_d = edge_ev;
    end else begin
      pend_d = pend_q | edge_ev | lvl_ev;
    end
  end

  // The edge history follows the pin whether masked or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      act_q   <= act;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter
  import irc_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       pending,
  input  irc_entry_t [NUM_PINS-1:0] entries,
  input  logic                      msg_ready,
  output logic                      msg_valid,
  output logic [7:0]                msg_vector,
  output logic [2:0]                msg_dlv_mode,
  output logic                      msg_dest_mode,
  output logic [7:0]                msg_dest,
  output logic                      msg_level,
  output logic [NUM_PINS-1:0]       ack,
  output logic [NUM_PINS-1:0]       rirr_set
);

  logic [NUM_PINS-1:0] sel_oh;
  logic [NUM_PINS-1:0] grant_q, grant_d;
  irc_entry_t          sel_ent;
  logic                load, hs;
  logic                valid_q, valid_d;
  logic [7:0]          vec_q, dest_q;
  logic [2:0]          dlv_q;
  logic                dmode_q, lvl_q;
  logic                unused_fields;

  // Lowest set bit wins
  assign sel_oh = pending & (~pending + 1'b1);

  always_comb begin
    sel_ent = ENTRY_RST;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (sel_oh[i]) begin
        sel_ent = entries[i];
      end
    end
  end

  assign unused_fields = ^{sel_ent.mask, sel_ent.pol};

  assign load = !valid_q && (pending != '0);
  assign hs   = valid_q && msg_ready;

  always_comb begin
    valid_d = valid_q;
    grant_d = grant_q;
    if (hs) begin
      valid_d = 1'b0;
    end else if (load) begin
      valid_d = 1'b1;
      grant_d = sel_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      grant_q <= '0;
    end else begin
      valid_q <= valid_d;
      grant_q <= grant_d;
    end
  end

  // Message payload, captured only on load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= 8'h00;
      dest_q  <= 8'h00;
      dlv_q   <= 3'b000;
      dmode_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else if (load) begin
      vec_q   <= sel_ent.vec;
      dest_q  <= sel_ent.dest;
      dlv_q   <= sel_ent.dlv;
      dmode_q <= sel_ent.dmode;
      lvl_q   <= sel_ent.trig;
    end
  end

  assign ack           = hs ? grant_q : '0;
  assign rirr_set      = (hs && lvl_q) ? grant_q : '0;
  assign msg_valid     = valid_q;
  assign msg_vector    = vec_q;
  assign msg_dlv_mode  = dlv_q;
  assign msg_dest_mode = dmode_q;
  assign msg_dest      = dest_q;
  assign msg_level     = lvl_q;

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irc_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                bus_en,
  input  logic                bus_wr,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dlv_mode,
  output logic                msg_dest_mode,
  output logic [7:0]          msg_dest,
  output logic                msg_level,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector
);

  irc_entry_t [NUM_PINS-1:0] ent_w;
  logic [NUM_PINS-1:0]       pend_w;
  logic [NUM_PINS-1:0]       rirr_w;
  logic [NUM_PINS-1:0]       ack_w;
  logic [NUM_PINS-1:0]       rset_w;

  irc_regfile #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pending    (pend_w),
    .rirr_set   (rset_w),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .entries    (ent_w),
    .rirr       (rirr_w)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irc_pin_sense u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (irq_pins[g]),
      .pol   (ent_w[g].pol),
      .trig  (ent_w[g].trig),
      .mask  (ent_w[g].mask),
      .rirr  (rirr_w[g]),
      .ack   (ack_w[g]),
      .pend  (pend_w[g])
    );
  end

  irc_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .pending       (pend_w),
    .entries       (ent_w),
    .msg_ready     (msg_ready),
    .msg_valid     (msg_valid),
    .msg_vector    (msg_vector),
    .msg_dlv_mode  (msg_dlv_mode),
    .msg_dest_mode (msg_dest_mode),
    .msg_dest      (msg_dest),
    .msg_level     (msg_level),
    .ack           (ack_w),
    .rirr_set      (rset_w)
  );

endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_vector,
  input logic [2:0]          msg_dlv_mode,
  input logic                msg_dest_mode,
  input logic [7:0]          msg_dest,
  input logic                msg_level,
  input logic                eoi_valid,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_PINS-1:0] rirr,
  input logic [NUM_PINS-1:0] ack
);

  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
      $stable(msg_dlv_mode) && $stable(msg_dest_mode) &&
      $stable(msg_dest) && $stable(msg_level)));

  assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_status_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (pending != '0));

  assert_rirr_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_level) |=> ($countones(rirr) > 0));

  assert_rirr_eoi_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |=> ((rirr & $past(rirr)) == $past(rirr)));

endmodule

bind irq_redirect_ctrl irc_checker #(.NUM_PINS(NUM_PINS)) u_irc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_vector    (msg_vector),
  .msg_dlv_mode  (msg_dlv_mode),
  .msg_dest_mode (msg_dest_mode),
  .msg_dest      (msg_dest),
  .msg_level     (msg_level),
  .eoi_valid     (eoi_valid),
  .pending       (pend_w),
  .rirr          (rirr_w),
  .ack           (ack_w)
);

// File: tb/test_irq_redirect_ctrl.sv
module test_irq_redirect_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] irq_pins;
  logic          bus_en, bus_wr;
  logic [4:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          msg_valid, msg_ready;
  logic [7:0]    msg_vector, msg_dest;
  logic [2:0]    msg_dlv_mode;
  logic          msg_dest_mode, msg_level;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;

  int tests = 0;
  int fails = 0;

  irq_redirect_ctrl #(.NUM_PINS(NP), .VERSION(8'h20)) i_irq_redirect_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv_mode(msg_dlv_mode), .msg_dest_mode(msg_dest_mode),
    .msg_dest(msg_dest), .msg_level(msg_level),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h10, 32'h0,        32'h00010000, 8'd1}, // R1 entry 0 low
    '{1'b0, 8'h11, 32'h0,        32'h00000000, 8'd1}, // R1 entry 0 high
    '{1'b0, 8'h3E, 32'h0,        32'h00010000, 8'd1}, // R1 last entry low
    '{1'b0, 8'h00, 32'h0,        32'h00000000, 8'd1}, // R1 ID
    '{1'b0, 8'h01, 32'h0,        32'h00170020, 8'd3}, // R3 version
    '{1'b1, 8'h00, 32'hA5FFFFFF, 32'h0,        8'd3},
    '{1'b0, 8'h00, 32'h0,        32'hA5000000, 8'd3}, // R3 ID bits
    '{1'b0, 8'h02, 32'h0,        32'h05000000, 8'd3}, // R3 arbitration
    '{1'b1, 8'h01, 32'hFFFFFFFF, 32'h0,        8'd3},
    '{1'b0, 8'h01, 32'h0,        32'h00170020, 8'd3}, // R3 read-only
    '{1'b1, 8'h12, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b0, 8'h12, 32'h0,        32'h0001AFFF, 8'd4}, // R4 status/rirr ignored
    '{1'b1, 8'h13, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b0, 8'h13, 32'h0,        32'hFF000000, 8'd4}, // R4 destination
    '{1'b0, 8'h12, 32'h0,        32'h0001AFFF, 8'd4}, // R4 halves independent
    '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b0, 8'h40, 32'h0,        32'h00000000, 8'd4}, // R4 past the table
    '{1'b1, 8'h12, 32'h00010000, 32'h0,        8'd4},
    '{1'b1, 8'h13, 32'h00000000, 32'h0,        8'd4},
    '{1'b0, 8'h13, 32'h0,        32'h00000000, 8'd4}  // R4 high cleared
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(5'h00, {24'h0, idx});
    bus_write(5'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(5'h00, {24'h0, idx});
    bus_read(5'h10, d);
  endtask

  task automatic wait_msg(output logic got);
    got = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      #1;
      if (msg_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic accept();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic quiet(input int n, output logic seen);
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      if (msg_valid) seen = 1'b1;
    end
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        got, seen;
    logic [7:0]  v0;
    rst_n = 1'b0; irq_pins = '0; bus_en = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; msg_ready = 1'b0;
    eoi_valid = 1'b0; eoi_vector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of outputs and index
    chk("R1 msg_valid", {31'h0, msg_valid}, 32'h0);
    bus_read(5'h00, rd);
    chk("R1 index", rd, 32'h0);

    // Register access table (R1, R3, R4)
    for (int r = 0; r < NV; r++) begin
      if (TBL[r].wr) begin
        reg_write(TBL[r].idx, TBL[r].data);
      end else begin
        reg_read(TBL[r].idx, rd);
        chk($sformatf("R%0d idx %h", TBL[r].req, TBL[r].idx), rd, TBL[r].exp);
      end
    end

    // R2 bus offsets
    bus_write(5'h00, 32'h00000037);
    bus_read(5'h00, rd);
    chk("R2 index readback", rd, 32'h37);
    bus_read(5'h08, rd);
    chk("R2 other offset reads 0", rd, 32'h0);
    bus_write(5'h08, 32'h000000AA);
    bus_read(5'h00, rd);
    chk("R2 other offset write ignored", rd, 32'h37);

    // R5/R9/R11 edge pin 2
    reg_write(8'h15, 32'h07000000);
    reg_write(8'h14, 32'h00000042);
    irq_pins[2] = 1'b1;
    wait_msg(got);
    chk("R5 edge message", {31'h0, got}, 32'h1);
    chk("R11 fields", {8'h0, msg_vector, msg_dest, 3'h0, msg_level, msg_dest_mode, msg_dlv_mode},
        {8'h0, 8'h42, 8'h07, 8'h00});
    reg_read(8'h14, rd);
    chk("R9 status pending", rd, 32'h00001042);
    v0 = msg_vector;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 held", {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, v0});
    accept();
    quiet(8, seen);
    chk("R5 held pin silent", {31'h0, seen}, 32'h0);
    reg_read(8'h14, rd);
    chk("R9 status cleared", rd, 32'h00000042);
    irq_pins[2] = 1'b0;
    repeat (4) @(negedge clk);
    irq_pins[2] = 1'b1;
    wait_msg(got);
    chk("R5 second edge", {24'h0, msg_vector}, {24'h0, got ? 8'h42 : 8'hXX});
    accept();
    irq_pins[2] = 1'b0;

    // R5/R6 active-low pin 3: polarity set while masked, then unmasked
    reg_write(8'h16, 32'h00012043);
    repeat (4) @(negedge clk);
    reg_write(8'h16, 32'h00002043);
    quiet(6, seen);
    chk("R6 unmask already-active silent", {31'h0, seen}, 32'h0);
    irq_pins[3] = 1'b1;
    repeat (4) @(negedge clk);
    irq_pins[3] = 1'b0;
    wait_msg(got);
    chk("R5 active-low edge", {23'h0, got, msg_vector}, {23'h0, 1'b1, 8'h43});
    accept();

    // R6 masked pin 4
    reg_write(8'h18, 32'h00010044);
    irq_pins[4] = 1'b1;
    quiet(8, seen);
    chk("R6 masked silent", {31'h0, seen}, 32'h0);
    reg_read(8'h18, rd);
    chk("R6 masked no status", rd, 32'h00010044);
    reg_write(8'h18, 32'h00000044);
    quiet(6, seen);
    chk("R6 unmask active edge pin silent", {31'h0, seen}, 32'h0);
    irq_pins[4] = 1'b0;

    // R7/R8 level pin 5
    reg_write(8'h1B, 32'h3C000000);
    reg_write(8'h1A, 32'h00008955);
    irq_pins[5] = 1'b1;
    wait_msg(got);
    chk("R7 level message", {8'h0, got, msg_vector, msg_dest, msg_level, msg_dest_mode, msg_dlv_mode},
        {8'h0, 1'b1, 8'h55, 8'h3C, 1'b1, 1'b1, 3'b001});
    accept();
    reg_read(8'h1A, rd);
    chk("R7 remote IRR set", rd, 32'h0000C955);
    quiet(8, seen);
    chk("R7 blocked while IRR set", {31'h0, seen}, 32'h0);
    send_eoi(8'h56);
    quiet(6, seen);
    chk("R8 wrong EOI no message", {31'h0, seen}, 32'h0);
    reg_read(8'h1A, rd);
    chk("R8 wrong EOI keeps IRR", rd, 32'h0000C955);
    send_eoi(8'h55);
    wait_msg(got);
    chk("R7 redelivery after EOI", {23'h0, got, msg_vector}, {23'h0, 1'b1, 8'h55});
    accept();
    irq_pins[5] = 1'b0;
    repeat (3) @(negedge clk);
    send_eoi(8'h55);
    quiet(6, seen);
    chk("R7 inactive after EOI silent", {31'h0, seen}, 32'h0);
    reg_read(8'h1A, rd);
    chk("R7 IRR cleared", rd, 32'h00008955);

    // R10 priority: pins 9 and 6 together
    reg_write(8'h22, 32'h00000069);
    reg_write(8'h1C, 32'h00000066);
    @(negedge clk);
    irq_pins[9] = 1'b1;
    irq_pins[6] = 1'b1;
    wait_msg(got);
    chk("R10 lowest first", {23'h0, got, msg_vector}, {23'h0, 1'b1, 8'h66});
    accept();
    wait_msg(got);
    chk("R10 next pin", {23'h0, got, msg_vector}, {23'h0, 1'b1, 8'h69});
    accept();
    quiet(6, seen);
    chk("R10 no extra", {31'h0, seen}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule